// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital front end of a two-channel 8-bit voltage converter. A host writes 16-bit words over a three-wire serial link: a serial clock, a data line and an active-low frame strobe. The three lines are brought into the system clock domain through two flops each. The block counts the clock rising edges seen while the strobe is low, and each one shifts one data bit in, most significant bit first. When the strobe rises after exactly sixteen bits, the upper byte of the word is decoded as a command and the lower byte is taken as the code.

Each channel is double buffered. An input register holds a staged code, and a converter register holds the code that is presented on the output. The command decides which registers load, from the word or from the staged value. One variant loads the staged value of one channel and then updates the outputs of both channels in the same step. Every accepted word also sets the two per-channel power-down flags and the reference-select flag. After reset, both outputs read code 0 until the first accepted word.

The serial input cannot apply back-pressure: every bit is taken when it arrives and nothing is ever stalled. The outputs are plain level signals that change only in the cycle after an accepted word.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both output codes are 0 and the power-down A, power-down B, external-reference and full power-down flags are 0.
- R2: A word is 16 bits sent MSB first. Bit 15 is the reference select (1 = external), bit 14 is ignored, bit 13 is the update-both command, bit 12 powers down B, bit 11 powers down A, bit 10 addresses the channel (0 = A, 1 = B), bits 9:8 are the load mode, and bits 7:0 are the code.
- R3: With bit 13 = 0 and mode 00, both output codes take the word's code.
- R4: With bit 13 = 0 and mode 01, the addressed channel's input register takes the code and neither output code changes.
- R5: With bit 13 = 0 and mode 10, the addressed output code takes the addressed input register's value, and the other channel is unchanged.
- R6: With bit 13 = 0 and mode 11, the addressed output code takes the word's code, and the other channel is unchanged.
- R7: With bit 13 = 1, the mode bits are ignored. The addressed input register and output code take the word's code, and the other output takes its own input register's value.
- R8: A frame with any bit count other than 16 while the strobe was low is discarded, and no output or flag changes.
- R9: Each accepted word loads the power-down A, power-down B and reference flags from bits 11, 12 and 15, and these bits never change a code or input register.
- R10: The full power-down flag is 1 exactly when both power-down flags are 1.
- R11: A word sent as two 8-bit bursts, with the strobe held low between them, acts the same as one 16-bit burst.
- R12: Outputs and flags change only in the cycle that follows the detection of a strobe rising edge that closes a valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| din_i | input | 1 | Serial data, MSB first |
| sync_n_i | input | 1 | Active-low frame strobe |
| code_a_o | output | 8 | Converter code, channel A |
| code_b_o | output | 8 | Converter code, channel B |
| pwdn_a_o | output | 1 | Channel A power-down flag |
| pwdn_b_o | output | 1 | Channel B power-down flag |
| ref_ext_o | output | 1 | External reference selected |
| full_pwdn_o | output | 1 | Both channels powered down |

## Verification
The assertions assume that the serial clock and the strobe each stay at a level for several system clocks, so that no edge is lost in the two-flop synchronisers. They also assume that data is stable around each serial clock rising edge. The stimulus holds every serial level for three system clocks and changes the data line only while the serial clock is low. It keeps the strobe high for many cycles between frames. Under these conditions the checks hold: outputs move only after an accepted frame, each frame gives one accept pulse, and the codes stay at zero until the first write.

// File: rtl/dual_dac_ctrl_pkg.sv
package dual_dac_ctrl_pkg;

  typedef struct packed {
    logic       ref_ext;
    logic       spare;
    logic       upd_both;
    logic       pd_b;
    logic       pd_a;
    logic       sel_b;
    logic [1:0] mode;
  } cmd_t;

  typedef struct packed {
    logic load_in;
    logic out_from_word;
    logic out_from_in;
  } ch_act_t;

  function automatic ch_act_t decode_ch(cmd_t c, logic addressed);
    ch_act_t a;
    a = '0;
    if (c.upd_both) begin
      a.load_in       = addressed;
      a.out_from_word = addressed;
      a.out_from_in   = !addressed;
    end else begin
      unique case (c.mode)
        2'b00: a.out_from_word = 1'b1;
        2'b01: a.load_in       = addressed;
        2'b10: a.out_from_in   = addressed;
        default: a.out_from_word = addressed;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/dual_dac_ctrl_rx.sv
module dual_dac_ctrl_rx #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               din_i,
  input  logic               sync_n_i,
  output logic               frame_v_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [2:0]         sclk_s;
  logic [1:0]         din_s;
  logic [2:0]         sync_s;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               sclk_rise, sync_rise, sync_low;

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sync_rise = sync_s[1] & ~sync_s[2];
  assign sync_low  = ~sync_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      din_s  <= '0;
      sync_s <= '1;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      din_s  <= {din_s[0], din_i};
      sync_s <= {sync_s[1:0], sync_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      frame_v_o <= 1'b0;
    end else begin
      frame_v_o <= 1'b0;
      if (sync_low) begin
        if (sclk_rise) begin
          shreg <= {shreg[FRAME_W-2:0], din_s[1]};
          if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        if (sync_rise && bit_cnt == CNT_FULL) frame_v_o <= 1'b1;
        bit_cnt <= '0;
      end
    end
  end

  assign frame_o = shreg;

endmodule

// File: rtl/dual_dac_ctrl_chan.sv
module dual_dac_ctrl_chan
  import dual_dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_v_i,
  input  ch_act_t           act_i,
  input  logic [CODE_W-1:0] word_code_i,
  input  logic              xparent_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] in_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (frame_v_i) begin
      if (act_i.load_in) in_q <= word_code_i;
      if (act_i.out_from_word)    out_q <= word_code_i;
      else if (act_i.out_from_in) out_q <= in_q;
    end
  end

  assign code_o = xparent_i ? in_q : out_q;

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              sync_n_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              pwdn_a_o,
  output logic              pwdn_b_o,
  output logic              ref_ext_o,
  output logic              full_pwdn_o
);
  localparam int unsigned CMD_W   = $bits(cmd_t);
  localparam int unsigned FRAME_W = CMD_W + CODE_W;
  localparam int unsigned NUM_CH  = 2;

  logic                           frame_v;
  logic [FRAME_W-1:0]             frame;
  cmd_t                           cmd;
  logic [CODE_W-1:0]              word_code;
  logic                           xparent;
  logic [NUM_CH-1:0][CODE_W-1:0]  codes;

  assign cmd       = cmd_t'(frame[FRAME_W-1:CODE_W]);
  assign word_code = frame[CODE_W-1:0];

  dual_dac_ctrl_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk_i),
    .din_i     (din_i),
    .sync_n_i  (sync_n_i),
    .frame_v_o (frame_v),
    .frame_o   (frame)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ch_act_t act;
    assign act = decode_ch(cmd, cmd.sel_b == 1'(ch));
    dual_dac_ctrl_chan #(.CODE_W(CODE_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_v_i   (frame_v),
      .act_i       (act),
      .word_code_i (word_code),
      .xparent_i   (xparent),
      .code_o      (codes[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xparent   <= 1'b1;
      pwdn_a_o  <= 1'b0;
      pwdn_b_o  <= 1'b0;
      ref_ext_o <= 1'b0;
    end else if (frame_v) begin
      xparent   <= 1'b0;
      pwdn_a_o  <= cmd.pd_a;
      pwdn_b_o  <= cmd.pd_b;
      ref_ext_o <= cmd.ref_ext;
    end
  end

  assign code_a_o    = codes[0];
  assign code_b_o    = codes[1];
  assign full_pwdn_o = pwdn_a_o & pwdn_b_o;

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_v,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              pd_a,
  input logic              pd_b,
  input logic              ref_ext,
  input logic              full_pd
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (frame_v) seen <= 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (code_a == '0 && code_b == '0 && !pd_a && !pd_b && !ref_ext)); // R1

  AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_v |=> ($stable(code_a) && $stable(code_b))); // R12

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_v |=> ($stable(pd_a) && $stable(pd_b) && $stable(ref_ext))); // R9

  AST_FULL_PD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_pd) |-> $past(frame_v)); // R10

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_v |=> !frame_v); // R8

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .frame_v (frame_v),
  .code_a  (code_a_o),
  .code_b  (code_b_o),
  .pd_a    (pwdn_a_o),
  .pd_b    (pwdn_b_o),
  .ref_ext (ref_ext_o),
  .full_pd (full_pwdn_o)
);

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, din = 1'b0, sync_n = 1'b1;
  logic [7:0] code_a, code_b;
  logic pd_a, pd_b, ref_ext, full_pd;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_dac_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .din_i(din), .sync_n_i(sync_n),
    .code_a_o(code_a), .code_b_o(code_b), .pwdn_a_o(pd_a), .pwdn_b_o(pd_b),
    .ref_ext_o(ref_ext), .full_pwdn_o(full_pd)
  );

  // {split, word[15:0], exp_a[7:0], exp_b[7:0], pd_a, pd_b, ref, full}
  localparam int NV = 11;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 16'h003C, 8'h3C, 8'h3C, 4'b0000},  // R3
    {1'b1, 16'h0111, 8'h3C, 8'h3C, 4'b0000},  // R4 R11
    {1'b0, 16'h0522, 8'h3C, 8'h3C, 4'b0000},  // R4
    {1'b0, 16'h02FF, 8'h11, 8'h3C, 4'b0000},  // R5
    {1'b1, 16'h0600, 8'h11, 8'h22, 4'b0000},  // R5
    {1'b0, 16'h079A, 8'h11, 8'h9A, 4'b0000},  // R6
    {1'b0, 16'h0140, 8'h11, 8'h9A, 4'b0000},  // R4
    {1'b0, 16'h2777, 8'h40, 8'h77, 4'b0000},  // R7
    {1'b1, 16'h8905, 8'h40, 8'h77, 4'b1010},  // R9 R2
    {1'b0, 16'h38E1, 8'hE1, 8'h77, 4'b1101},  // R7 R10
    {1'b0, 16'h03FF, 8'hFF, 8'h77, 4'b0000}   // R6 R9
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [7:0] ea, logic [7:0] eb, logic [3:0] fl);
    chk({tag, " code_a"}, code_a, ea);
    chk({tag, " code_b"}, code_b, eb);
    chk({tag, " flags"}, {4'b0, pd_a, pd_b, ref_ext, full_pd}, {4'b0, fl});
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [16:0] w, int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      din = w[i];
      wclk(3);
      sclk = 1'b1;
      wclk(3);
      sclk = 1'b0;
    end
  endtask

  task automatic send(logic [16:0] w, int nb, bit split);
    sync_n = 1'b0;
    wclk(3);
    if (split && nb == 16) begin
      send_bits({1'b0, w[15:8], 8'h00} >> 8, 8);
      wclk(20);
      send_bits({9'b0, w[7:0]}, 8);
    end else begin
      send_bits(w, nb);
    end
    wclk(3);
    sync_n = 1'b1;
    wclk(12);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk_all("R1 reset", 8'h00, 8'h00, 4'b0000);

    // R8: short frame with power-down bits set before any write
    send({1'b0, 16'h1855}, 15, 1'b0);
    chk_all("R8 short first", 8'h00, 8'h00, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      send({1'b0, VEC[i][35:20]}, 16, VEC[i][36]);
      chk_all($sformatf("R2 vec%0d", i), VEC[i][19:12], VEC[i][11:4], VEC[i][3:0]);
    end

    // R8: short frame loading both outputs is discarded
    send({1'b0, 16'h9800}, 15, 1'b0);
    chk_all("R8 short", 8'hFF, 8'h77, 4'b0000);
    // R8: long frame is discarded
    send({1'b1, 16'h9800}, 17, 1'b0);
    chk_all("R8 long", 8'hFF, 8'h77, 4'b0000);
    // R2: bit 14 ignored, mode 00 with spare bit set
    send({1'b0, 16'h4066}, 16, 1'b0);
    chk_all("R2 spare", 8'h66, 8'h66, 4'b0000);

    // R1: reset again after writes
    rst_n = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    chk_all("R1 rereset", 8'h00, 8'h00, 4'b0000);
    // R4 R1: input-only load after reset keeps outputs at zero
    send({1'b0, 16'h01AA}, 16, 1'b0);
    chk_all("R4 after reset", 8'h00, 8'h00, 4'b0000);
    // R5: copy staged value
    send({1'b0, 16'h0200}, 16, 1'b0);
    chk_all("R5 after reset", 8'hAA, 8'h00, 4'b0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule